// File: doc/BRIEF.md
# Slot Interrupt Router

The router takes interrupt pin requests from devices on an expansion bus and funnels them onto a single interrupt line for the CPU's interrupt controller. Each request names a slot (0 to 15) and an interrupt pin (0 to 3 for INTA to INTD). It also carries a request level and a valid strobe. A fixed table turns the slot and pin into an internal line index. That index picks one bit out of two 32-bit control words: a trigger-select word and a polarity word.

If the trigger-select bit is set, the request gives a single-cycle pulse on the output. If it is clear, the output is driven to the polarity bit and holds there. Slots outside the table are dropped. The routed line number, offset by a base of 32, is registered on an output port together with a one-cycle valid flag, so the routing can be observed.

Top module: `irq_router`

## Requirements
- R1: After reset, `irq_o`, `line_vld_o` and `line_num_o` are all 0.
- R2: A valid request from slot 5 on pin p routes to line 32+p, seen on `line_num_o` one cycle later.
- R3: Slot 6 routes to line 36 and slot 7 routes to line 37, whatever the pin.
- R4: Slot s in 8..12 on pin p routes to line 32 + (s−8+p) + 6, giving lines 38 up to 45.
- R5: A valid request from any slot outside 5..12 gives `line_vld_o` = 0 on the next cycle. It leaves `line_num_o` unchanged, and it leaves `irq_o` unchanged except that a pending pulse still ends.
- R6: When bit (line−32) of `edge_sel_i` is set, `irq_o` is 1 in the cycle after the request. It returns to 0 one cycle later unless another routed request arrives.
- R7: When that bit of `edge_sel_i` is clear, `irq_o` takes bit (line−32) of `polarity_i` in the cycle after the request. It holds that value until the next routed request.
- R8: `req_level_i` has no effect on any output.
- R9: `line_vld_o` is 1 exactly in the cycle after each routed request and 0 otherwise. `line_num_o` keeps the last routed line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_slot_i | input | 4 | Requesting slot number |
| req_pin_i | input | 2 | Interrupt pin, 0..3 = INTA..INTD |
| req_level_i | input | 1 | Request level (not used for routing or drive) |
| edge_sel_i | input | 32 | Per-line trigger select, 1 = pulse |
| polarity_i | input | 32 | Per-line level value used when not pulsing |
| irq_o | output | 1 | Interrupt line to the CPU controller |
| line_vld_o | output | 1 | A routed request was taken last cycle |
| line_num_o | output | 6 | Last routed line number, base 32 |

## Verification
The properties check the following on every cycle:
- routed line numbers stay within 32..45;
- slots 6 and 7 fire a pulse when their trigger-select bit is set, and the pulse drops once the requests stop;
- slot 5 follows the polarity word when not pulsing;
- unrouted slots and idle cycles never raise the line.

Some behaviour is only shown by the bench's directed and seeded random scenarios:
- the exact routing of the wide slots 8..12;
- back-to-back requests that restart a pulse or replace a held level;
- an unrouted request that arrives in the cycle a pulse is ending;
- independence from the request level.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int CTRL_W     = 32;
  localparam int IDX_W      = $clog2(CTRL_W);
  localparam int HUB_SLOT   = 5;
  localparam int GFX_SLOT   = 6;
  localparam int NET_SLOT   = 7;
  localparam int GFX_LINE   = 4;
  localparam int NET_LINE   = 5;
  localparam int WIDE_FIRST = 8;
  localparam int WIDE_LAST  = 12;
  localparam int WIDE_OFS   = 6;
  localparam int HUB_PINS   = 4;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } route_t;
endpackage

// File: rtl/irq_slot_map.sv
module irq_slot_map
  import irq_router_pkg::*;
#(
  parameter int SLOT_W = 4,
  parameter int PIN_W  = 2
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [PIN_W-1:0]  pin_i,
  output route_t            route_o
);
  localparam int NUM_WIDE = WIDE_LAST - WIDE_FIRST + 1;

  logic [NUM_WIDE-1:0]  wide_hit;
  logic [IDX_W-1:0]     wide_idx [NUM_WIDE];

  // one decode lane per wide slot
  for (genvar g = 0; g < NUM_WIDE; g++) begin : g_wide
    assign wide_hit[g] = (slot_i == SLOT_W'(WIDE_FIRST + g));
    assign wide_idx[g] = IDX_W'(g + WIDE_OFS) + IDX_W'(pin_i);
  end

  always_comb begin
    route_o = '0;
    if (slot_i == SLOT_W'(HUB_SLOT)) begin
      route_o.hit = 1'b1;
      route_o.idx = IDX_W'(32'(pin_i) % HUB_PINS);
    end else if (slot_i == SLOT_W'(GFX_SLOT)) begin
      route_o.hit = 1'b1;
      route_o.idx = IDX_W'(GFX_LINE);
    end else if (slot_i == SLOT_W'(NET_SLOT)) begin
      route_o.hit = 1'b1;
      route_o.idx = IDX_W'(NET_LINE);
    end else begin
      for (int k = 0; k < NUM_WIDE; k++) begin
        if (wide_hit[k]) begin
          route_o.hit = 1'b1;
          route_o.idx = wide_idx[k];
        end
      end
    end
  end
endmodule

// File: rtl/irq_trig_sel.sv
module irq_trig_sel
  import irq_router_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [CTRL_W-1:0] edge_sel_i,
  input  logic [CTRL_W-1:0] polarity_i,
  output logic              is_edge_o,
  output logic              pol_o
);
  assign is_edge_o = edge_sel_i[idx_i];
  assign pol_o     = polarity_i[idx_i];
endmodule

// File: rtl/irq_drive.sv
module irq_drive
  import irq_router_pkg::*;
#(
  parameter int LINE_BASE = 32,
  parameter int NUM_W     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             is_edge_i,
  input  logic             pol_i,
  output logic             irq_o,
  output logic             line_vld_o,
  output logic [NUM_W-1:0] line_num_o
);
  logic irq_q, pend_q, vld_q;
  logic [NUM_W-1:0] num_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
      num_q  <= '0;
    end else begin
      vld_q <= take_i;
      if (take_i) begin
        num_q <= NUM_W'(LINE_BASE) + NUM_W'(idx_i);
        if (is_edge_i) begin
          irq_q  <= 1'b1;
          pend_q <= 1'b1;
        end else begin
          irq_q  <= pol_i;
          pend_q <= 1'b0;
        end
      end else if (pend_q) begin
        // pulse ends
        irq_q  <= 1'b0;
        pend_q <= 1'b0;
      end
    end
  end

  assign irq_o      = irq_q;
  assign line_vld_o = vld_q;
  assign line_num_o = num_q;
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int LINE_BASE = 32,
  parameter int SLOT_W    = 4,
  parameter int PIN_W     = 2,
  parameter int NUM_W     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [SLOT_W-1:0] req_slot_i,
  input  logic [PIN_W-1:0]  req_pin_i,
  input  logic              req_level_i,
  input  logic [CTRL_W-1:0] edge_sel_i,
  input  logic [CTRL_W-1:0] polarity_i,
  output logic              irq_o,
  output logic              line_vld_o,
  output logic [NUM_W-1:0]  line_num_o
);
  route_t route;
  logic   is_edge, pol_bit, take;
  logic   unused_level;

  assign unused_level = req_level_i;

  irq_slot_map #(.SLOT_W(SLOT_W), .PIN_W(PIN_W)) u_map (
    .slot_i (req_slot_i),
    .pin_i  (req_pin_i),
    .route_o(route)
  );

  irq_trig_sel u_sel (
    .idx_i     (route.idx),
    .edge_sel_i(edge_sel_i),
    .polarity_i(polarity_i),
    .is_edge_o (is_edge),
    .pol_o     (pol_bit)
  );

  assign take = req_valid_i & route.hit;

  irq_drive #(.LINE_BASE(LINE_BASE), .NUM_W(NUM_W)) u_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .idx_i     (route.idx),
    .is_edge_i (is_edge),
    .pol_i     (pol_bit),
    .irq_o     (irq_o),
    .line_vld_o(line_vld_o),
    .line_num_o(line_num_o)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int LINE_BASE = 32,
  parameter int SLOT_W    = 4,
  parameter int PIN_W     = 2,
  parameter int NUM_W     = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [SLOT_W-1:0] req_slot_i,
  input logic [PIN_W-1:0]  req_pin_i,
  input logic [31:0]       edge_sel_i,
  input logic [31:0]       polarity_i,
  input logic              irq_o,
  input logic              line_vld_o,
  input logic [NUM_W-1:0]  line_num_o
);
  logic out_of_table;
  assign out_of_table = (req_slot_i < SLOT_W'(5)) || (req_slot_i > SLOT_W'(12));

  assert_line_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_vld_o |-> (line_num_o >= NUM_W'(LINE_BASE)) && (line_num_o <= NUM_W'(LINE_BASE + 13)));

  assert_fixed_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && (req_slot_i == SLOT_W'(6)) |=> line_vld_o && (line_num_o == NUM_W'(LINE_BASE + 4)));

  assert_edge_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && (req_slot_i == SLOT_W'(6)) && edge_sel_i[4] |=> irq_o);

  assert_pulse_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && (req_slot_i == SLOT_W'(7)) && edge_sel_i[5] ##1 !req_valid_i |=> !irq_o);

  assert_level_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && (req_slot_i == SLOT_W'(5)) && !edge_sel_i[req_pin_i]
    |=> irq_o == $past(polarity_i[req_pin_i]));

  assert_unrouted_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && out_of_table && !irq_o |=> !irq_o && !line_vld_o);

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !line_vld_o);
endmodule

bind irq_router irq_router_chk #(
  .LINE_BASE(LINE_BASE), .SLOT_W(SLOT_W), .PIN_W(PIN_W), .NUM_W(NUM_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_slot_i (req_slot_i),
  .req_pin_i  (req_pin_i),
  .edge_sel_i (edge_sel_i),
  .polarity_i (polarity_i),
  .irq_o      (irq_o),
  .line_vld_o (line_vld_o),
  .line_num_o (line_num_o)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  slot = '0;
  logic [1:0]  pin = '0;
  logic        lvl = 1'b0;
  logic [31:0] es = '0;
  logic [31:0] pol = '0;
  logic        irq;
  logic        vld;
  logic [5:0]  num;

  int n_tests = 0;
  int n_fail  = 0;

  // model state
  logic       m_irq = 1'b0, m_pend = 1'b0, m_vld = 1'b0;
  logic [5:0] m_num = '0;

  always #4 clk = ~clk;

  irq_router u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_slot_i(slot),
    .req_pin_i(pin), .req_level_i(lvl), .edge_sel_i(es), .polarity_i(pol),
    .irq_o(irq), .line_vld_o(vld), .line_num_o(num)
  );

  // routing table from R2..R5; -1 = not routed
  function automatic int route_of(input int s, input int p);
    if (s == 5) return p % 4;
    if (s == 6) return 4;
    if (s == 7) return 5;
    if (s >= 8 && s <= 12) return (s - 8 + p) + 6;
    return -1;
  endfunction

  function automatic string tag_of(input int s);
    if (s == 5) return "R2";
    if (s == 6 || s == 7) return "R3";
    if (s >= 8 && s <= 12) return "R4";
    return "R5";
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive at negedge, sample at following negedge
  task automatic step(input logic v, input int s, input int p, input logic l,
                      input logic [31:0] e, input logic [31:0] pl, input string req);
    int idx;
    valid = v; slot = 4'(s); pin = 2'(p); lvl = l; es = e; pol = pl;
    @(negedge clk);
    idx = route_of(s, p);
    if (v && idx >= 0) begin
      m_vld = 1'b1;
      m_num = 6'(32 + idx);
      if (e[idx]) begin m_irq = 1'b1; m_pend = 1'b1; end
      else begin m_irq = pl[idx]; m_pend = 1'b0; end
    end else begin
      m_vld = 1'b0;
      if (m_pend) begin m_irq = 1'b0; m_pend = 1'b0; end
    end
    chk(req, "line_num_o", int'(num), int'(m_num));
    chk(req, "line_vld_o", int'(vld), int'(m_vld));
    chk(req, "irq_o", int'(irq), int'(m_irq));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f2e_3d4c));
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", "irq_o", int'(irq), 0);
    chk("R1", "line_vld_o", int'(vld), 0);
    chk("R1", "line_num_o", int'(num), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 hub slot, level mode, each pin
    for (int p = 0; p < 4; p++) step(1, 5, p, 0, 32'h0, 32'h0000_0005, "R2");
    // R3 fixed slots, all pins
    for (int p = 0; p < 4; p++) step(1, 6, p, 1, 32'h0, 32'h10, "R3");
    for (int p = 0; p < 4; p++) step(1, 7, p, 0, 32'h0, 32'h0, "R3");
    // R4 wide slots, every pin
    for (int s = 8; s <= 12; s++)
      for (int p = 0; p < 4; p++) step(1, s, p, 0, 32'h0, 32'h0000_2a40, "R4");
    // R7 level set then hold through idle
    step(1, 6, 0, 0, 32'h0, 32'h10, "R7");
    step(0, 0, 0, 0, 32'h0, 32'h0, "R7");
    step(0, 0, 0, 0, 32'h0, 32'h0, "R9");
    // R6 pulse then drop
    step(1, 7, 2, 0, 32'h20, 32'h0, "R6");
    step(0, 0, 0, 0, 32'h20, 32'h0, "R6");
    // R6 back-to-back pulses
    step(1, 9, 1, 0, 32'h100, 32'h0, "R6");
    step(1, 9, 1, 0, 32'h100, 32'h0, "R6");
    step(0, 0, 0, 0, 32'h0, 32'h0, "R6");
    // R5 unrouted during pulse end, and with level held high
    step(1, 12, 3, 0, 32'h2000, 32'h0, "R6");
    step(1, 13, 0, 0, 32'hffff_ffff, 32'hffff_ffff, "R5");
    step(1, 5, 1, 0, 32'h0, 32'h2, "R7");
    step(1, 0, 2, 1, 32'hffff_ffff, 32'h0, "R5");
    step(1, 15, 3, 0, 32'h0, 32'h0, "R5");
    step(1, 4, 0, 0, 32'h0, 32'h0, "R5");
    // R8 level input flips, outputs match same stimulus
    step(1, 10, 2, 0, 32'h0, 32'h400, "R8");
    step(1, 10, 2, 1, 32'h0, 32'h400, "R8");
    step(1, 11, 0, 1, 32'h200, 32'h0, "R8");
    step(0, 11, 0, 0, 32'h200, 32'h0, "R8");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int s, p;
      s = int'($urandom % 16);
      p = int'($urandom % 4);
      step(($urandom % 4) != 0, s, p, 1'($urandom), $urandom, $urandom, tag_of(s));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule